// File: doc/BRIEF.md
# Layered port range encoder

This block turns a 16-bit transport-layer port number into a 16-bit layered code. A ternary search stage can then match one stored pattern per rule instead of a list of prefixes. A table of ranges is programmed into the block. Each range has a low bound, a high bound, a layer number, a code value and an enable flag. A second small table gives the width of each layer's bit field.

The fields are packed from the most significant bit downward: layer 0 comes first, then each later layer follows toward the LSB. For each layer, the block finds the enabled range that contains the port and writes that range's code into the layer's field. A layer with no such range leaves its field at zero. Source and destination ports use two separate instances of the block. Computing the table contents is done elsewhere.

A lookup is presented with `in_valid` and `in_port`. The code appears on `out_code` one clock later, with `out_valid` high.

Top module: `port_layer_encoder`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `out_code` is 0, all table entries are disabled and all layer widths are 0, so any lookup yields code 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_code` keeps its value while no lookup is presented.
- R3: Range membership includes both bounds: a port equal to the low bound or the high bound matches, and one past the high bound does not.
- R4: A layer with no enabled matching range contributes all-zero bits to its field.
- R5: Layer 0's field sits at bits [15:16-w0]. Layer k's field ends at bit 16 minus the sum of widths of layers 0..k-1. Bits below the last field are 0. Example: with widths 1,2,2,1 and only `[0,65535]` with code 1 in layer 0, port 123 encodes as `16'h8000`.
- R6: With widths 1 and 3, `[0,65535]` with code 1 in layer 0, and `[0,22]` with code 3'b010 in layer 1, port 22 encodes as `16'hA000`.
- R7: If two enabled ranges of the same layer both contain the port, the one at the lower table address supplies the code.
- R8: Only the low w bits of a range's code are used, where w is its layer's width. Higher code bits are ignored.
- R9: A table write takes effect for lookups in later cycles. A lookup in the same cycle as a write sees the old contents.
- R10: A disabled entry never matches.
- R11: A layer whose field would extend past bit 0 (cumulative width above 16) contributes nothing.
- R12: An entry whose low bound exceeds its high bound matches no port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_entry_we | input | 1 | Write one range entry |
| cfg_addr | input | 5 | Entry address |
| cfg_enable | input | 1 | Enable flag of the written entry |
| cfg_lo | input | 16 | Low bound (inclusive) |
| cfg_hi | input | 16 | High bound (inclusive) |
| cfg_layer | input | 2 | Layer of the written entry |
| cfg_code | input | 16 | Code value of the written entry |
| cfg_width_we | input | 1 | Write one layer width |
| cfg_width_layer | input | 2 | Layer whose width is written |
| cfg_width | input | 5 | Field width in bits |
| in_valid | input | 1 | Lookup request |
| in_port | input | 16 | Port number to encode |
| out_valid | output | 1 | Code valid, one cycle after request |
| out_code | output | 16 | Layered code |

## Verification
A table write and a lookup can land in the same clock cycle. The bench provokes this by disabling the only layer-0 entry while looking up a port that this entry covers. The result of that lookup must still carry the old layer-0 bit. A second lookup in the following cycle must show that bit cleared. This fixes the ordering rule of R9 at the ports.

// File: rtl/ple_pkg.sv
package ple_pkg;
  localparam int unsigned PLE_MASK_W = 64;

  function automatic logic [PLE_MASK_W-1:0] ple_low_ones(input int unsigned n);
    if (n >= PLE_MASK_W) return '1;
    return (PLE_MASK_W'(1) << n) - PLE_MASK_W'(1);
  endfunction
endpackage

// File: rtl/ple_range_table.sv
module ple_range_table #(
  parameter int PORT_W  = 16,
  parameter int CODE_W  = 16,
  parameter int ENTRIES = 32,
  parameter int LAYERS  = 4,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int LYR_W  = $clog2(LAYERS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               en,
  input  logic [PORT_W-1:0]                  lo,
  input  logic [PORT_W-1:0]                  hi,
  input  logic [LYR_W-1:0]                   layer,
  input  logic [CODE_W-1:0]                  code,
  input  logic [PORT_W-1:0]                  port,
  output logic [LAYERS-1:0][ENTRIES-1:0]     hit,
  output logic [ENTRIES-1:0][CODE_W-1:0]     code_o
);
  logic [ENTRIES-1:0]             en_q;
  logic [ENTRIES-1:0][PORT_W-1:0] lo_q;
  logic [ENTRIES-1:0][PORT_W-1:0] hi_q;
  logic [ENTRIES-1:0][LYR_W-1:0]  lyr_q;
  logic [ENTRIES-1:0][CODE_W-1:0] code_q;

  // enable flags carry the reset; payload words are plain storage
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (we) en_q[addr] <= en;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      lo_q[addr]   <= lo;
      hi_q[addr]   <= hi;
      lyr_q[addr]  <= layer;
      code_q[addr] <= code;
    end
  end

  assign code_o = code_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic inside_rng;
    assign inside_rng = en_q[e] && (port >= lo_q[e]) && (port <= hi_q[e]);
    for (genvar l = 0; l < LAYERS; l++) begin : g_lyr
      assign hit[l][e] = inside_rng && (lyr_q[e] == LYR_W'(l));
    end
  end
endmodule

// File: rtl/ple_layer_select.sv
module ple_layer_select #(
  parameter int CODE_W  = 16,
  parameter int ENTRIES = 32,
  parameter int LAYERS  = 4
) (
  input  logic [LAYERS-1:0][ENTRIES-1:0] hit,
  input  logic [ENTRIES-1:0][CODE_W-1:0] code_i,
  output logic [LAYERS-1:0]              lay_hit,
  output logic [LAYERS-1:0][CODE_W-1:0]  lay_code
);
  for (genvar l = 0; l < LAYERS; l++) begin : g_lyr
    // scan from the top so the lowest matching index is written last
    always_comb begin
      lay_hit[l]  = 1'b0;
      lay_code[l] = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (hit[l][e]) begin
          lay_hit[l]  = 1'b1;
          lay_code[l] = code_i[e];
        end
      end
    end
  end
endmodule

// File: rtl/ple_field_pack.sv
module ple_field_pack
  import ple_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int LAYERS = 4,
  localparam int LYR_W = $clog2(LAYERS),
  localparam int WID_W = $clog2(CODE_W + 1),
  localparam int ACC_W = 2 * CODE_W
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             width_we,
  input  logic [LYR_W-1:0]                 width_layer,
  input  logic [WID_W-1:0]                 width_val,
  input  logic [LAYERS-1:0]                lay_hit,
  input  logic [LAYERS-1:0][CODE_W-1:0]    lay_code,
  output logic [CODE_W-1:0]                packed_code
);
  logic [LAYERS-1:0][WID_W-1:0] wid_q;

  always_ff @(posedge clk) begin
    if (rst) wid_q <= '0;
    else if (width_we) wid_q[width_layer] <= width_val;
  end

  logic [ACC_W-1:0]      acc;
  logic [ACC_W-1:0]      fld;
  logic [PLE_MASK_W-1:0] msk;
  int                    cum;

  always_comb begin
    acc = '0;
    fld = '0;
    msk = '0;
    cum = 0;
    for (int l = 0; l < LAYERS; l++) begin
      cum = cum + int'(wid_q[l]);
      if (lay_hit[l] && (wid_q[l] != '0) && (cum <= CODE_W)) begin
        msk = ple_low_ones(int'(wid_q[l]));
        fld = ACC_W'(lay_code[l] & msk[CODE_W-1:0]);
        acc = acc | (fld << (CODE_W - cum));
      end
    end
    packed_code = acc[CODE_W-1:0];
  end
endmodule

// File: rtl/port_layer_encoder.sv
module port_layer_encoder #(
  parameter int PORT_W      = 16,
  parameter int CODE_W      = 16,
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_LAYERS  = 4,
  localparam int ADDR_W = $clog2(NUM_ENTRIES),
  localparam int LYR_W  = $clog2(NUM_LAYERS),
  localparam int WID_W  = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_entry_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_enable,
  input  logic [PORT_W-1:0] cfg_lo,
  input  logic [PORT_W-1:0] cfg_hi,
  input  logic [LYR_W-1:0]  cfg_layer,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_width_we,
  input  logic [LYR_W-1:0]  cfg_width_layer,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_port,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code
);
  logic [NUM_LAYERS-1:0][NUM_ENTRIES-1:0] ent_hit;
  logic [NUM_ENTRIES-1:0][CODE_W-1:0]     ent_code;
  logic [NUM_LAYERS-1:0]                  lay_hit;
  logic [NUM_LAYERS-1:0][CODE_W-1:0]      lay_code;
  logic [CODE_W-1:0]                      code_nxt;

  ple_range_table #(
    .PORT_W(PORT_W), .CODE_W(CODE_W), .ENTRIES(NUM_ENTRIES), .LAYERS(NUM_LAYERS)
  ) u_table (
    .clk(clk), .rst(rst), .we(cfg_entry_we), .addr(cfg_addr), .en(cfg_enable),
    .lo(cfg_lo), .hi(cfg_hi), .layer(cfg_layer), .code(cfg_code),
    .port(in_port), .hit(ent_hit), .code_o(ent_code)
  );

  ple_layer_select #(
    .CODE_W(CODE_W), .ENTRIES(NUM_ENTRIES), .LAYERS(NUM_LAYERS)
  ) u_select (
    .hit(ent_hit), .code_i(ent_code), .lay_hit(lay_hit), .lay_code(lay_code)
  );

  ple_field_pack #(
    .CODE_W(CODE_W), .LAYERS(NUM_LAYERS)
  ) u_pack (
    .clk(clk), .rst(rst), .width_we(cfg_width_we), .width_layer(cfg_width_layer),
    .width_val(cfg_width), .lay_hit(lay_hit), .lay_code(lay_code),
    .packed_code(code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= code_nxt;
    end
  end
endmodule

// File: rtl/ple_checker.sv
module ple_checker #(
  parameter int CODE_W = 16,
  parameter int LAYERS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [LAYERS-1:0] lay_hit,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_code == '0));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_code_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_code));

  p_no_hit_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lay_hit == '0) |=> (out_code == '0));
endmodule

bind port_layer_encoder ple_checker #(
  .CODE_W(CODE_W), .LAYERS(NUM_LAYERS)
) u_ple_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .lay_hit(lay_hit),
  .out_valid(out_valid), .out_code(out_code)
);

// File: tb/port_layer_encoder_tb_top.sv
module port_layer_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_entry_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic        cfg_enable = 1'b0;
  logic [15:0] cfg_lo = '0;
  logic [15:0] cfg_hi = '0;
  logic [1:0]  cfg_layer = '0;
  logic [15:0] cfg_code = '0;
  logic        cfg_width_we = 1'b0;
  logic [1:0]  cfg_width_layer = '0;
  logic [4:0]  cfg_width = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_port = '0;
  logic        out_valid;
  logic [15:0] out_code;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  port_layer_encoder dut_i (
    .clk(clk), .rst(rst), .cfg_entry_we(cfg_entry_we), .cfg_addr(cfg_addr),
    .cfg_enable(cfg_enable), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_layer(cfg_layer),
    .cfg_code(cfg_code), .cfg_width_we(cfg_width_we), .cfg_width_layer(cfg_width_layer),
    .cfg_width(cfg_width), .in_valid(in_valid), .in_port(in_port),
    .out_valid(out_valid), .out_code(out_code)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic put_entry(input int a, input bit en, input int lo, input int hi,
                           input int lyr, input int code);
    @(negedge clk);
    cfg_entry_we = 1'b1; cfg_addr = 5'(a); cfg_enable = en;
    cfg_lo = 16'(lo); cfg_hi = 16'(hi); cfg_layer = 2'(lyr); cfg_code = 16'(code);
    @(negedge clk);
    cfg_entry_we = 1'b0;
  endtask

  task automatic put_width(input int lyr, input int w);
    @(negedge clk);
    cfg_width_we = 1'b1; cfg_width_layer = 2'(lyr); cfg_width = 5'(w);
    @(negedge clk);
    cfg_width_we = 1'b0;
  endtask

  task automatic lookup(input string req, input int port, input logic [15:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_port = 16'(port);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 valid", {15'd0, out_valid}, 16'd1);
    check(req, out_code, exp);
  endtask

  task automatic t_reset;
    check("R1 valid after reset", {15'd0, out_valid}, 16'd0);
    check("R1 code after reset", out_code, 16'h0000);
    lookup("R1 empty table", 5, 16'h0000);
  endtask

  task automatic t_hold;
    @(negedge clk);
    check("R2 idle valid", {15'd0, out_valid}, 16'd0);
    check("R2 idle hold", out_code, 16'h8000);
  endtask

  task automatic t_src_example;
    put_width(0, 1); put_width(1, 2); put_width(2, 2); put_width(3, 1);
    put_entry(0, 1, 0, 65535, 0, 1);
    lookup("R5 port 123", 123, 16'h8000);
  endtask

  task automatic t_dst_example;
    put_width(1, 3); put_width(2, 0); put_width(3, 0);
    put_entry(1, 1, 0, 22, 1, 2);
    lookup("R6 port 22", 22, 16'hA000);
    lookup("R3 one past high", 23, 16'h8000);
    put_entry(2, 1, 52, 53, 1, 3);
    lookup("R3 low bound", 52, 16'hB000);
    lookup("R3 high bound", 53, 16'hB000);
    lookup("R4 no layer1 hit", 54, 16'h8000);
  endtask

  task automatic t_overlap;
    put_entry(3, 1, 50, 60, 1, 5);
    lookup("R7 lower index wins", 52, 16'hB000);
    lookup("R7 sole match", 55, 16'hD000);
  endtask

  task automatic t_mask_and_layout;
    put_entry(4, 1, 1000, 1000, 1, 16'hFFFE);
    lookup("R8 code masked", 1000, 16'hE000);
    put_width(2, 4);
    put_entry(5, 1, 1000, 2000, 2, 9);
    lookup("R5 three fields", 1000, 16'hE900);
  endtask

  task automatic t_overflow_disable;
    put_width(3, 10);
    put_entry(6, 1, 1000, 1000, 3, 1);
    lookup("R11 field past bit 0", 1000, 16'hE900);
    put_width(3, 8);
    lookup("R5 field ends at bit 0", 1000, 16'hE901);
    put_entry(6, 0, 1000, 1000, 3, 1);
    lookup("R10 disabled entry", 1000, 16'hE900);
  endtask

  task automatic t_inverted;
    put_entry(7, 1, 500, 400, 2, 15);
    lookup("R12 inverted bounds", 450, 16'h8000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_entry_we = 1'b1; cfg_addr = 5'd0; cfg_enable = 1'b0;
    cfg_lo = 16'd0; cfg_hi = 16'hFFFF; cfg_layer = 2'd0; cfg_code = 16'd1;
    in_valid = 1'b1; in_port = 16'd123;
    @(negedge clk);
    cfg_entry_we = 1'b0;
    check("R9 same-cycle sees old", out_code, 16'h8000);
    in_port = 16'd123;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next cycle sees new", out_code, 16'h0000);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_src_example();
    t_hold();
    t_dst_example();
    t_overlap();
    t_mask_and_layout();
    t_overflow_disable();
    t_inverted();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule